// File: doc/BRIEF.md
# Subtract-Based Compare and Condition Evaluator

This block compares two unsigned-or-signed integers of a parameterized width (default 4 bits, usable up to 32). It forms the difference `opa - opb` by feeding `opa`, the bitwise complement of `opb` and a carry-in of one into a single adder. From that one subtraction it derives four flags: borrow, sign, zero and overflow. A condition decoder then combines the flags to answer a branch question chosen by a 4-bit condition code.

The code can ask for equality, inequality, any of the four unsigned orderings or any of the four signed orderings. The answer comes out as one `taken` bit, and the raw flags and the difference are also driven on outputs.

The unit has no clock and no state. All outputs settle combinationally from the present inputs, so a surrounding pipeline can register them wherever its timing allows. Because there is no data stream, the block has no valid/ready handshake and no back-pressure; every pin is a plain level.

Top module: `cmpc_eval`

## Requirements
- R1: `diff` equals (`opa` + bitwise-not `opb` + 1) modulo 2^W, i.e. `opa - opb` wrapped to W bits.
- R2: `flag_c` is 1 exactly when `opa` read as unsigned is smaller than `opb` read as unsigned (for W=4, 3 - 5 gives `diff`=1110 with `flag_c`=1).
- R3: `flag_n` equals the top bit of `diff`, and `flag_z` is 1 exactly when every bit of `diff` is 0.
- R4: `flag_v` is 1 exactly when the true signed difference lies outside the W-bit two's complement range (for W=4, -8 - 1 gives `diff`=0111 with `flag_v`=1).
- R5: Condition code 0 (equal) makes `taken` = `flag_z`, and code 1 (not equal) makes `taken` = not `flag_z`; both hold for signed and unsigned operands alike.
- R6: Unsigned codes: 2 (below) gives `flag_c`; 3 (above-or-equal) gives not `flag_c`; 4 (below-or-equal) gives `flag_c` or `flag_z`; 5 (above) gives neither `flag_c` nor `flag_z`.
- R7: Signed codes: 6 (less) gives `flag_n` xor `flag_v`; 7 (greater-or-equal) gives its inverse; 8 (less-or-equal) gives the xor or `flag_z`; 9 (greater) gives the xor clear and `flag_z` clear.
- R8: Condition codes 10 through 15 always give `taken` = 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | Minuend |
| opb | input | W | Subtrahend |
| cond_sel | input | 4 | Condition code selecting the relation to test |
| diff | output | W | Wrapped difference opa - opb |
| flag_c | output | 1 | Borrow: unsigned opa < opb |
| flag_n | output | 1 | Sign: top bit of diff |
| flag_z | output | 1 | Zero: diff is all zeros |
| flag_v | output | 1 | Signed overflow of the subtraction |
| taken | output | 1 | Result of the selected condition |

## Verification
Signed and unsigned ordering come from the same subtraction in the same cycle, and they can disagree. An example is opa=1111 and opb=0001, which is above when read as unsigned but less when read as signed. Borrow and overflow can also be set together, as with 0111 - 1000.

The bench walks every operand pair at width 4 under every one of the sixteen condition codes, one combination per clock, so all such coincidences occur. On each cycle it compares `taken`, `diff` and all four flags against a reference. That reference is built from plain integer arithmetic and native signed and unsigned relations, not from the flags.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;

  // Condition selector encoding; codes above CC_SGT are unused and return not-taken.
  typedef enum logic [3:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_ULT = 4'd2,
    CC_UGE = 4'd3,
    CC_ULE = 4'd4,
    CC_UGT = 4'd5,
    CC_SLT = 4'd6,
    CC_SGE = 4'd7,
    CC_SLE = 4'd8,
    CC_SGT = 4'd9
  } cond_e;

  typedef struct packed {
    logic c;  // borrow (inverted adder carry-out)
    logic n;  // sign
    logic z;  // zero
    logic v;  // signed overflow
  } flags_t;

  // Adder construction variants.
  localparam int ADD_RIPPLE = 0;
  localparam int ADD_NATIVE = 1;

endpackage

// File: rtl/cmpc_adder.sv
module cmpc_adder #(
  parameter int W     = 4,
  parameter int STYLE = cmpc_pkg::ADD_RIPPLE
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  generate
    if (STYLE == cmpc_pkg::ADD_RIPPLE) begin : g_ripple
      logic [W:0] cc;
      assign cc[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = x[i] ^ y[i] ^ cc[i];
        assign cc[i+1] = (x[i] & y[i]) | (cc[i] & (x[i] ^ y[i]));
      end
      assign cout = cc[W];
    end else begin : g_native
      logic [W:0] wide;
      assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
      assign sum  = wide[W-1:0];
      assign cout = wide[W];
    end
  endgenerate

endmodule

// File: rtl/cmpc_flags.sv
module cmpc_flags #(
  parameter int W = 4
) (
  input  logic              a_msb,
  input  logic              b_msb,
  input  logic [W-1:0]      dif,
  input  logic              carry_out,
  output cmpc_pkg::flags_t  flg
);

  localparam int MSB = W - 1;

  always_comb begin
    flg.c = ~carry_out;                              // no carry-out means a borrow occurred
    flg.n = dif[MSB];
    flg.z = ~|dif;
    flg.v = (a_msb ^ b_msb) & (dif[MSB] ^ a_msb);    // operand signs differ and result sign left a's
  end

endmodule

// File: rtl/cmpc_cond.sv
module cmpc_cond (
  input  cmpc_pkg::flags_t flg,
  input  logic [3:0]       sel,
  output logic             hit
);
  import cmpc_pkg::*;

  logic lt_s;

  always_comb begin
    lt_s = flg.n ^ flg.v;
    case (sel)
      CC_EQ:   hit = flg.z;
      CC_NE:   hit = ~flg.z;
      CC_ULT:  hit = flg.c;
      CC_UGE:  hit = ~flg.c;
      CC_ULE:  hit = flg.c | flg.z;
      CC_UGT:  hit = ~flg.c & ~flg.z;
      CC_SLT:  hit = lt_s;
      CC_SGE:  hit = ~lt_s;
      CC_SLE:  hit = lt_s | flg.z;
      CC_SGT:  hit = ~lt_s & ~flg.z;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmpc_eval.sv
module cmpc_eval #(
  parameter int W         = 4,
  parameter int ADD_STYLE = cmpc_pkg::ADD_RIPPLE
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   cond_sel,
  output logic [W-1:0] diff,
  output logic         flag_c,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         taken
);

  localparam int MSB = W - 1;

  logic [W-1:0]     opb_inv;
  logic [W-1:0]     sub_res;
  logic             sub_cout;
  cmpc_pkg::flags_t flg;

  assign opb_inv = ~opb;

  cmpc_adder #(.W(W), .STYLE(ADD_STYLE)) u_add (
    .x    (opa),
    .y    (opb_inv),
    .cin  (1'b1),
    .sum  (sub_res),
    .cout (sub_cout)
  );

  cmpc_flags #(.W(W)) u_flags (
    .a_msb     (opa[MSB]),
    .b_msb     (opb[MSB]),
    .dif       (sub_res),
    .carry_out (sub_cout),
    .flg       (flg)
  );

  cmpc_cond u_cond (
    .flg (flg),
    .sel (cond_sel),
    .hit (taken)
  );

  assign diff   = sub_res;
  assign flag_c = flg.c;
  assign flag_n = flg.n;
  assign flag_z = flg.z;
  assign flag_v = flg.v;

endmodule

// File: rtl/cmpc_eval_chk.sv
module cmpc_eval_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   cond_sel,
  input logic [W-1:0] diff,
  input logic         flag_c,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_v,
  input logic         taken
);

  logic signed [W:0] sdiff_wide;

  always_comb begin
    sdiff_wide = $signed({opa[W-1], opa}) - $signed({opb[W-1], opb});

    p_diff_wrap_r1: assert (diff == W'(opa - opb))
      else $error("diff does not wrap opa-opb");
    p_borrow_r2: assert (flag_c == (opa < opb))
      else $error("borrow disagrees with unsigned order");
    p_zero_r3: assert (flag_z == (opa == opb))
      else $error("zero flag disagrees with operand equality");
    p_sign_r3: assert (flag_n == diff[W-1])
      else $error("sign flag disagrees with diff msb");
    p_no_overflow_r4: assert (flag_v == (sdiff_wide[W] != sdiff_wide[W-1]))
      else $error("overflow flag disagrees with signed range");
    p_eq_r5: assert (cond_sel != 4'd0 || taken == (opa == opb))
      else $error("equal condition wrong");
    p_ult_r6: assert (cond_sel != 4'd2 || taken == (opa < opb))
      else $error("unsigned below wrong");
    p_slt_r7: assert (cond_sel != 4'd6 || taken == ($signed(opa) < $signed(opb)))
      else $error("signed less wrong");
    p_unused_r8: assert (cond_sel < 4'd10 || !taken)
      else $error("unused code taken");
  end

endmodule

bind cmpc_eval cmpc_eval_chk #(.W(W)) u_chk (
  .opa      (opa),
  .opb      (opb),
  .cond_sel (cond_sel),
  .diff     (diff),
  .flag_c   (flag_c),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_v   (flag_v),
  .taken    (taken)
);

// File: tb/tb_cmpc_eval.sv
module tb_cmpc_eval;

  localparam int W    = 4;
  localparam int SPAN = 1 << W;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opa, opb;
  logic [3:0]   cond_sel;
  logic [W-1:0] diff;
  logic         flag_c, flag_n, flag_z, flag_v, taken;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  cmpc_eval #(.W(W)) dut (
    .opa(opa), .opb(opb), .cond_sel(cond_sel),
    .diff(diff), .flag_c(flag_c), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .taken(taken)
  );

  initial clk = 0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d sel=%0d actual=%0d expected=%0d",
               req, opa, opb, cond_sel, act, exp);
    end
  endtask

  function automatic int to_s(input int u);
    return (u >= SPAN / 2) ? u - SPAN : u;
  endfunction

  // Behavioural reference for the condition result from native relations.
  function automatic bit ref_taken(input int ua, input int ub, input int code);
    int sa = to_s(ua);
    int sb = to_s(ub);
    case (code)
      0: return ua == ub;
      1: return ua != ub;
      2: return ua <  ub;
      3: return ua >= ub;
      4: return ua <= ub;
      5: return ua >  ub;
      6: return sa <  sb;
      7: return sa >= sb;
      8: return sa <= sb;
      9: return sa >  sb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input int ua, input int ub, input int code);
    @(posedge clk);
    #2;
    opa      = W'(ua);
    opb      = W'(ub);
    cond_sel = 4'(code);
    @(negedge clk);
  endtask

  task automatic check_all(input int ua, input int ub, input int code);
    int sd  = to_s(ua) - to_s(ub);
    int ed  = (ua - ub + SPAN) % SPAN;
    bit ec  = ua < ub;
    bit en  = ed >= SPAN / 2;
    bit ez  = ed == 0;
    bit ev  = (sd < -(SPAN / 2)) || (sd > SPAN / 2 - 1);
    bit et  = ref_taken(ua, ub, code);
    chk(int'(diff) == ed, "R1 diff", int'(diff), ed);
    chk(flag_c == ec, "R2 borrow", flag_c, ec);
    chk(flag_n == en && flag_z == ez, "R3 sign/zero", {flag_n, flag_z}, {en, ez});
    chk(flag_v == ev, "R4 overflow", flag_v, ev);
    if (code <= 1)      chk(taken == et, "R5 eq/ne", taken, et);
    else if (code <= 5) chk(taken == et, "R6 unsigned", taken, et);
    else if (code <= 9) chk(taken == et, "R7 signed", taken, et);
    else                chk(taken == et, "R8 unused code", taken, et);
  endtask

  initial begin
    opa = '0; opb = '0; cond_sel = 4'd0; rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // Initial state: zero operands, equal condition.
    chk(taken == 1'b1 && flag_z == 1'b1, "R5 initial equal", taken, 1);

    // Named corner cases.
    apply(3, 5, 2);    // 3-5: 1110 with borrow
    chk(diff == 4'b1110 && flag_c, "R2 3-5 borrow", {diff, flag_c}, {4'b1110, 1'b1});
    apply(8, 1, 6);    // -8-1: 0111 with overflow
    chk(diff == 4'b0111 && flag_v, "R4 -8-1 overflow", {diff, flag_v}, {4'b0111, 1'b1});
    apply(15, 1, 5);   // unsigned above
    chk(taken == 1'b1, "R6 1111 above 0001", taken, 1);
    apply(15, 1, 6);   // same bits, signed less
    chk(taken == 1'b1, "R7 1111 less 0001", taken, 1);
    apply(7, 8, 9);    // borrow and overflow together, signed greater
    chk(flag_c && flag_v && taken, "R7 7 greater -8", {flag_c, flag_v, taken}, 7);
    apply(5, 5, 12);   // unused code on equal operands
    chk(taken == 1'b0, "R8 unused code 12", taken, 0);

    // Exhaustive sweep, one combination per clock.
    for (int code = 0; code < 16; code++)
      for (int ua = 0; ua < SPAN; ua++)
        for (int ub = 0; ub < SPAN; ub++) begin
          apply(ua, ub, code);
          check_all(ua, ub, code);
        end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule